// File: doc/BRIEF.md
# ADC Serial Frame Controller

This block is a serial-interface master for a sampling analog-to-digital converter. It drives the converter's active-low chip-select and its serial clock, samples the converter's serial data line, and hands back a 12-bit result word with a one-cycle valid strobe. A host starts a conversion frame with a single-cycle start request. It then watches a busy level and a done pulse. The converter channel to use in the next frame is presented on a channel-select output.

A converter can wake from power-up in a long 32-clock frame mode. In that mode it stays silent when it receives short frames. To force it back into 16-clock mode, the first frame after reset is a recovery frame: it carries one extra falling clock edge and has its own chip-select hold rule. A sticky flag records that this frame has gone out. Every later frame is a normal short frame.

All timing is counted in system clocks. The two chip-select hold times are given in picoseconds and converted to clock counts, rounded up. The serial-clock half period, the lead time from chip-select to clock, and the minimum chip-select high time between frames are parameters.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is asserted, chip-select, serial clock and power-down enable are all driven low, and `sample_vld_o` is low. The power-down enable output is always low.
- R2: The first frame after reset delivers exactly RECOV_EDGES (default 15) falling serial-clock edges while chip-select is low.
- R3: Every frame after the first delivers exactly NORM_EDGES (default 14) falling serial-clock edges while chip-select is low.
- R4: In the first frame, chip-select stays low for exactly ceil(RECOV_HOLD_PS / SYS_CLK_PS) clocks (at least 1) after the last falling edge. The default is 1 clock.
- R5: In later frames, chip-select stays low for exactly ceil(NORM_HOLD_PS / SYS_CLK_PS) clocks (at least 1) after the last falling edge. The default is 2 clocks.
- R6: The serial clock idles low and is low whenever chip-select is high. Chip-select idles high once reset is released. At least one clock passes between chip-select falling and the first serial-clock rise.
- R7: The data line is sampled on each serial-clock rise. The bit taken at rise 3 becomes result bit 11, and so on down to rise 14, which becomes bit 0. The bits from rises 1, 2 and 15 are discarded. `sample_o` updates together with a one-cycle `sample_vld_o` pulse that coincides with `done_o`.
- R8: `chan_sel_o` stays 0 until the recovery frame has completed. Starts accepted before then do not take `chan_i`. After that, `chan_i` is latched when a start is accepted, and `chan_sel_o` is stable while chip-select is low.
- R9: `recov_done_o` is low from reset until the first frame ends, then stays high until the next reset.
- R10: A start request while `busy_o` is high is ignored and produces no extra frame.
- R11: Chip-select stays high for at least GAP_CLKS clocks before any frame begins, including the first frame after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion frame |
| chan_i | input | CH_W | Channel for the requested frame |
| busy_o | output | 1 | High while a frame or the inter-frame gap is in progress |
| done_o | output | 1 | One-cycle pulse when a frame ends |
| recov_done_o | output | 1 | Sticky flag: recovery frame has been sent |
| sample_o | output | SAMPLE_W | Captured result word |
| sample_vld_o | output | 1 | One-cycle strobe for `sample_o` |
| chan_sel_o | output | CH_W | Channel-select toward the converter |
| adc_cs_n_o | output | 1 | Active-low chip-select toward the converter |
| adc_sclk_o | output | 1 | Serial clock toward the converter |
| adc_pd_en_o | output | 1 | Power-down enable toward the converter (held low) |
| adc_sdo_i | input | 1 | Serial data from the converter |

## Verification
The bench feeds the data line with fifteen-bit patterns. Walking ones over every result position show whether each rise lands in the right bit, and whether the two leading bits and the fifteenth bit are really dropped. All-ones, all-zeros, alternating and pseudo-random words catch shift-direction and stuck-bit faults.

A monitor counts falling edges, the hold time after the last edge, and the high gap of every frame. This tells the recovery frame apart from normal frames, and it is re-run after a second reset. Back-to-back starts, including a start pulse issued mid-frame, separate a correctly ignored request from a spurious extra frame or a channel change.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_GAP,
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_HOLD
  } fr_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // hold time in picoseconds -> clocks, rounded up, never below one clock
  function automatic int hold_clks(input int hold_ps, input int period_ps);
    int c;
    c = ceil_div(hold_ps, period_ps);
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_frame_pkg::*;
#(
  parameter int HALF_CLKS   = 2,
  parameter int LEAD_CLKS   = 1,
  parameter int GAP_CLKS    = 3,
  parameter int HOLD_R      = 1,
  parameter int HOLD_N      = 2,
  parameter int NORM_EDGES  = 14,
  parameter int RECOV_EDGES = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic cs_n_o,
  output logic sclk_o,
  output logic recov_done_o,
  output logic frame_go_o,
  output logic shift_en_o,
  output logic load_o
);

  localparam int CNT_MAX = max_i(max_i(HALF_CLKS, LEAD_CLKS), max_i(max_i(GAP_CLKS, HOLD_R), HOLD_N));
  localparam int CW = $clog2(CNT_MAX + 1) + 1;
  localparam int EW = $clog2(RECOV_EDGES + 1);
  localparam logic [CW-1:0] HALF_LAST  = CW'(HALF_CLKS - 1);
  localparam logic [CW-1:0] LEAD_LAST  = CW'(LEAD_CLKS - 1);
  localparam logic [CW-1:0] GAP_LAST   = CW'(GAP_CLKS - 1);
  localparam logic [CW-1:0] HOLDR_LAST = CW'(HOLD_R - 1);
  localparam logic [CW-1:0] HOLDN_LAST = CW'(HOLD_N - 1);
  localparam logic [EW-1:0] RECOV_E    = EW'(RECOV_EDGES);
  localparam logic [EW-1:0] NORM_E     = EW'(NORM_EDGES);

  fr_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [EW-1:0] falls_q;
  logic          sclk_q, first_q, recov_q, done_q;

  // named internal events
  logic          tick, rise_ev, fall_ev, last_fall, hold_end, accept;
  logic [EW-1:0] target;
  logic [CW-1:0] hold_last;

  assign tick      = (st_q == ST_SHIFT) && (cnt_q == HALF_LAST);
  assign rise_ev   = tick && !sclk_q;
  assign fall_ev   = tick && sclk_q;
  assign target    = first_q ? RECOV_E : NORM_E;
  assign last_fall = fall_ev && ((falls_q + 1'b1) == target);
  assign hold_last = first_q ? HOLDR_LAST : HOLDN_LAST;
  assign hold_end  = (st_q == ST_HOLD) && (cnt_q == hold_last);
  assign accept    = (st_q == ST_IDLE) && start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_PWR;
      cnt_q   <= '0;
      falls_q <= '0;
      sclk_q  <= 1'b0;
      first_q <= 1'b0;
      recov_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= hold_end;
      if (hold_end) recov_q <= 1'b1;
      unique case (st_q)
        ST_PWR: begin
          st_q  <= ST_GAP;
          cnt_q <= '0;
        end
        ST_GAP: begin
          if (cnt_q == GAP_LAST) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_IDLE: begin
          if (accept) begin
            st_q    <= ST_LEAD;
            cnt_q   <= '0;
            first_q <= !recov_q;
          end
        end
        ST_LEAD: begin
          if (cnt_q == LEAD_LAST) begin
            st_q    <= ST_SHIFT;
            cnt_q   <= '0;
            falls_q <= '0;
            sclk_q  <= 1'b0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_SHIFT: begin
          if (tick) begin
            cnt_q  <= '0;
            sclk_q <= !sclk_q;
            if (fall_ev) falls_q <= falls_q + 1'b1;
            if (last_fall) st_q <= ST_HOLD;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_HOLD: begin
          if (hold_end) begin
            st_q  <= ST_GAP;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_PWR;
      endcase
    end
  end

  assign cs_n_o       = (st_q == ST_GAP) || (st_q == ST_IDLE);
  assign sclk_o       = sclk_q;
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign recov_done_o = recov_q;
  assign frame_go_o   = accept;
  assign shift_en_o   = rise_ev && (falls_q < NORM_E);
  assign load_o       = hold_end;

  // ---------------- checker state, counted from the pins ----------------
  logic          sclk_d;
  logic [EW-1:0] chk_falls;
  logic [CW:0]   chk_gap;
  logic [CW:0]   chk_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      chk_falls <= '0;
      chk_gap   <= '0;
      chk_hold  <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (cs_n_o) chk_falls <= '0;
      else if (sclk_d && !sclk_o) chk_falls <= chk_falls + 1'b1;
      if (!cs_n_o) chk_gap <= '0;
      else if (chk_gap != '1) chk_gap <= chk_gap + 1'b1;
      if (sclk_o || cs_n_o) chk_hold <= '0;
      else if (chk_hold != '1) chk_hold <= chk_hold + 1'b1;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n_o |-> !sclk_o); // R6
  AST_RECOV_EDGES: assert property (@(posedge clk) disable iff (!rst_n) ($rose(cs_n_o) && done_o && first_q) |-> (chk_falls == RECOV_E)); // R2
  AST_NORM_EDGES: assert property (@(posedge clk) disable iff (!rst_n) ($rose(cs_n_o) && done_o && !first_q) |-> (chk_falls == NORM_E)); // R3
  AST_RECOV_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ($rose(cs_n_o) && done_o && first_q) |-> (chk_hold >= (CW+1)'(HOLD_R))); // R4
  AST_NORM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ($rose(cs_n_o) && done_o && !first_q) |-> (chk_hold >= (CW+1)'(HOLD_N))); // R5
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n_o) |-> (chk_gap >= (CW+1)'(GAP_CLKS))); // R11
  AST_RECOV_STICKY: assert property (@(posedge clk) disable iff (!rst_n) recov_done_o |=> recov_done_o); // R9
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && start_i) |=> !$fell(cs_n_o)); // R10

endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
  parameter int NORM_EDGES = 14,
  parameter int SAMPLE_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                shift_en_i,
  input  logic                sdo_i,
  input  logic                load_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                vld_o
);

  localparam int SH_W = NORM_EDGES;

  logic [SH_W-1:0]     sh_q;
  logic [SAMPLE_W-1:0] sample_q;
  logic                vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      sample_q <= '0;
      vld_q    <= 1'b0;
    end else begin
      if (clr_i) sh_q <= '0;
      else if (shift_en_i) sh_q <= {sh_q[SH_W-2:0], sdo_i};
      vld_q <= load_i;
      if (load_i) sample_q <= sh_q[SAMPLE_W-1:0];
    end
  end

  assign sample_o = sample_q;
  assign vld_o    = vld_q;

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) vld_o |=> !vld_o); // R7
  AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rst_n) !vld_o |-> $stable(sample_o)); // R7

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int SYS_CLK_PS    = 5000,
  parameter int RECOV_HOLD_PS = 3500,
  parameter int NORM_HOLD_PS  = 10000,
  parameter int HALF_CLKS     = 2,
  parameter int LEAD_CLKS     = 1,
  parameter int GAP_CLKS      = 3,
  parameter int CH_W          = 3,
  parameter int SAMPLE_W      = 12,
  parameter int NORM_EDGES    = 14,
  parameter int RECOV_EDGES   = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [CH_W-1:0]     chan_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                recov_done_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_vld_o,
  output logic [CH_W-1:0]     chan_sel_o,
  output logic                adc_cs_n_o,
  output logic                adc_sclk_o,
  output logic                adc_pd_en_o,
  input  logic                adc_sdo_i
);

  localparam int HOLD_R = hold_clks(RECOV_HOLD_PS, SYS_CLK_PS);
  localparam int HOLD_N = hold_clks(NORM_HOLD_PS, SYS_CLK_PS);

  logic frame_go, shift_en, load;
  logic [CH_W-1:0] chan_q;

  adc_frame_seq #(
    .HALF_CLKS  (HALF_CLKS),
    .LEAD_CLKS  (LEAD_CLKS),
    .GAP_CLKS   (GAP_CLKS),
    .HOLD_R     (HOLD_R),
    .HOLD_N     (HOLD_N),
    .NORM_EDGES (NORM_EDGES),
    .RECOV_EDGES(RECOV_EDGES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .cs_n_o      (adc_cs_n_o),
    .sclk_o      (adc_sclk_o),
    .recov_done_o(recov_done_o),
    .frame_go_o  (frame_go),
    .shift_en_o  (shift_en),
    .load_o      (load)
  );

  adc_rx_shift #(
    .NORM_EDGES(NORM_EDGES),
    .SAMPLE_W  (SAMPLE_W)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (frame_go),
    .shift_en_i(shift_en),
    .sdo_i     (adc_sdo_i),
    .load_i    (load),
    .sample_o  (sample_o),
    .vld_o     (sample_vld_o)
  );

  // channel may only move once the recovery frame is out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_q <= '0;
    else if (frame_go && recov_done_o) chan_q <= chan_i;
  end

  assign chan_sel_o  = chan_q;
  assign adc_pd_en_o = 1'b0;

  AST_CHAN_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!adc_cs_n_o && $past(!adc_cs_n_o)) |-> $stable(chan_sel_o)); // R8
  AST_CHAN_ZERO_EARLY: assert property (@(posedge clk) disable iff (!rst_n) !recov_done_o |-> (chan_sel_o == '0)); // R8
  AST_VLD_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) sample_vld_o |-> done_o); // R7

endmodule

// File: tb/tb_adc_frame_ctrl.sv
`timescale 1ns/1ps
module tb_adc_frame_ctrl;

  localparam int PER_PS  = 5000;
  localparam int GAPC    = 3;
  localparam int EXP_HR  = ((3500 + PER_PS - 1) / PER_PS < 1) ? 1 : (3500 + PER_PS - 1) / PER_PS;
  localparam int EXP_HN  = ((10000 + PER_PS - 1) / PER_PS < 1) ? 1 : (10000 + PER_PS - 1) / PER_PS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  chan_i = 3'd0;
  logic        busy_o, done_o, recov_done_o, sample_vld_o;
  logic [11:0] sample_o;
  logic [2:0]  chan_sel_o;
  logic        adc_cs_n_o, adc_sclk_o, adc_pd_en_o;
  logic        adc_sdo_i = 1'b0;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  adc_frame_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
    .busy_o(busy_o), .done_o(done_o), .recov_done_o(recov_done_o),
    .sample_o(sample_o), .sample_vld_o(sample_vld_o), .chan_sel_o(chan_sel_o),
    .adc_cs_n_o(adc_cs_n_o), .adc_sclk_o(adc_sclk_o), .adc_pd_en_o(adc_pd_en_o),
    .adc_sdo_i(adc_sdo_i)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- pin monitor and converter model ----------------
  logic [14:0] pat = '0;
  int  frames = 0, falls = 0, rises = 0, hold = 0, gap = 0, lead = 0;
  bit  open = 0, cs_p = 0, sclk_p = 0, idle_bad = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      frames = 0; open = 0; gap = 0; cs_p = 0; sclk_p = 0; rises = 0;
      adc_sdo_i = 1'b0;
    end else begin
      if (adc_cs_n_o && adc_sclk_o) idle_bad = 1;
      if (!adc_cs_n_o && cs_p) begin
        chk(gap >= GAPC, "R11", "cs high gap", gap, GAPC);
        open = 1; falls = 0; rises = 0; hold = 0; lead = 0;
      end
      if (!adc_cs_n_o) begin
        if (adc_sclk_o && !sclk_p) begin
          rises++;
          if (rises == 1) chk(lead >= 1, "R6", "lead before first rise", lead, 1);
        end
        if (rises == 0) lead++;
        if (!adc_sclk_o && sclk_p) begin
          falls++; hold = 1;
        end else if (!adc_sclk_o && falls > 0) hold++;
      end
      if (adc_cs_n_o && !cs_p && open) begin
        if (frames == 0) begin
          chk(falls == 15, "R2", "recovery frame falling edges", falls, 15);
          chk(hold == EXP_HR, "R4", "recovery hold clocks", hold, EXP_HR);
        end else begin
          chk(falls == 14, "R3", "normal frame falling edges", falls, 14);
          chk(hold == EXP_HN, "R5", "normal hold clocks", hold, EXP_HN);
        end
        chk(idle_bad == 0, "R6", "sclk low while cs high", int'(idle_bad), 0);
        frames++; open = 0; gap = 0;
      end
      if (adc_cs_n_o) gap++;
      adc_sdo_i = (!adc_cs_n_o && rises < 15) ? pat[14 - rises] : 1'b0;
      cs_p = adc_cs_n_o; sclk_p = adc_sclk_o;
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  task automatic run_frame(input logic [14:0] p, input logic [2:0] ch, input logic [2:0] exp_ch, input string tag);
    wait_idle();
    pat = p; chan_i = ch; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (!done_o) @(negedge clk);
    chk(sample_vld_o == 1'b1, "R7", {tag, " valid with done"}, int'(sample_vld_o), 1);
    chk(sample_o == p[12:1], "R7", {tag, " sample word"}, int'(sample_o), int'(p[12:1]));
    chk(chan_sel_o == exp_ch, "R8", {tag, " channel select"}, int'(chan_sel_o), int'(exp_ch));
    @(negedge clk);
    chk(sample_vld_o == 1'b0, "R7", {tag, " valid is one cycle"}, int'(sample_vld_o), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(adc_cs_n_o == 1'b0, "R1", "cs low in reset", int'(adc_cs_n_o), 0);
    chk(adc_sclk_o == 1'b0, "R1", "sclk low in reset", int'(adc_sclk_o), 0);
    chk(adc_pd_en_o == 1'b0, "R1", "pd_en low in reset", int'(adc_pd_en_o), 0);
    chk(sample_vld_o == 1'b0, "R1", "valid low in reset", int'(sample_vld_o), 0);
    rst_n = 1'b1;
    wait_idle();
    chk(adc_cs_n_o == 1'b1, "R6", "cs idles high", int'(adc_cs_n_o), 1);
    chk(recov_done_o == 1'b0, "R9", "flag clear after reset", int'(recov_done_o), 0);
  endtask

  initial begin
    logic [14:0] lfsr;
    int f0;
    do_reset();
    // recovery frame: rise 15 bit set, must be dropped; channel request ignored
    run_frame(15'b010_1101_0010_1101, 3'd5, 3'd0, "recovery");
    chk(recov_done_o == 1'b1, "R9", "flag set after first frame", int'(recov_done_o), 1);

    // start while busy is ignored
    wait_idle();
    f0 = frames;
    pat = 15'h2AAA; chan_i = 3'd2; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (4) @(negedge clk);
    chan_i = 3'd6; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (!done_o) @(negedge clk);
    chk(chan_sel_o == 3'd2, "R8", "channel unchanged by busy start", int'(chan_sel_o), 2);
    repeat (80) @(negedge clk);
    chk(frames == f0 + 1, "R10", "no extra frame from busy start", frames, f0 + 1);
    chk(recov_done_o == 1'b1, "R9", "flag stays set", int'(recov_done_o), 1);

    // walking ones across each result bit, plus the discarded positions
    for (int i = 0; i < 15; i++) begin
      logic [2:0] c = 3'(i % 8);
      run_frame(15'(1 << i), c, c, "walk");
    end
    run_frame(15'h7FFF, 3'd7, 3'd7, "ones");
    run_frame(15'h0000, 3'd0, 3'd0, "zeros");
    run_frame(15'h5555, 3'd3, 3'd3, "alt");
    lfsr = 15'h1ACE;
    for (int k = 0; k < 24; k++) begin
      lfsr = {lfsr[13:0], lfsr[14] ^ lfsr[13]};
      run_frame(lfsr, 3'(k), 3'(k), "prbs");
    end

    // second reset: flag clears, recovery frame repeats, channel pinned to 0 again
    do_reset();
    chk(chan_sel_o == 3'd0, "R8", "channel zero after reset", int'(chan_sel_o), 0);
    run_frame(15'h3C3C, 3'd4, 3'd0, "recovery2");
    run_frame(15'h0F0F, 3'd4, 3'd4, "after2");
    chk(adc_pd_en_o == 1'b0, "R1", "pd_en stays low", int'(adc_pd_en_o), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule